// File: doc/BRIEF.md
# Shared-Subtractor Magnitude and Equality Comparator

This block compares two N-bit operands, a and b, with a single subtractor. It forms b minus a as b plus the bitwise inverse of a plus one, and from that one sum derives the five condition flags: carry, zero, negative, overflow and the true signed sign. The same flags then answer both the unsigned and the signed "a is below b" question, so no second comparator is needed when the operand interpretation changes.

A mode input picks which interpretation drives the single less-than output. Equality is produced twice: once as the zero flag of the difference and once as an all-ones test over the bitwise XNOR of the operands. The two must always agree. The block is purely combinational. A parameter chooses between an explicit ripple chain of full-adder cells and a behavioural add for the subtractor.

Top module: `sub_cmp_top`

## Requirements
- R1: flag_c is the carry-out of b + ~a + 1, so it is 1 exactly when b >= a as unsigned numbers.
- R2: flag_z is 1 exactly when every bit of (b - a) mod 2^WIDTH is 0, that is, when a equals b.
- R3: flag_n equals bit WIDTH-1 of (b - a) mod 2^WIDTH.
- R4: flag_v is 1 exactly when bit WIDTH-1 of a differs from bit WIDTH-1 of b and bit WIDTH-1 of the difference differs from bit WIDTH-1 of b.
- R5: flag_s equals flag_n XOR flag_v and is 1 exactly when b < a as two's-complement numbers.
- R6: a_eq_b, taken from the all-ones test over a XNOR b, is 1 exactly when a equals b and always matches flag_z.
- R7: With signed_mode = 0, a_lt_b is 1 exactly when a < b as unsigned numbers (flag_c = 1 and flag_z = 0).
- R8: With signed_mode = 1, a_lt_b is 1 exactly when a < b as two's-complement numbers (flag_s = 0 and flag_z = 0).
- R9: The most negative signed value (only bit WIDTH-1 set) and the all-ones value compare correctly against every other operand in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand subtracted from b |
| b | input | WIDTH | Operand from which a is subtracted |
| signed_mode | input | 1 | 0: unsigned compare, 1: two's-complement compare |
| flag_c | output | 1 | Carry-out of the subtraction |
| flag_z | output | 1 | Difference is zero |
| flag_n | output | 1 | Most significant bit of the difference |
| flag_v | output | 1 | Signed overflow of the subtraction |
| flag_s | output | 1 | True sign of b - a for signed operands |
| a_lt_b | output | 1 | a below b under the selected mode |
| a_eq_b | output | 1 | a equals b, from the XNOR detector |

## Verification
The immediate assertions in the top check on every input change that the XNOR equality agrees with the zero flag, that a zero difference always carries, that overflow only appears when the operand signs differ, and that the selected less-than output matches a native comparison of the operands in either mode. What the assertions cannot show is the exact flag pattern for each operand pair, such as the negative and overflow bits at the wrap from the most negative value; the bench sweeps every pair of a narrow configuration in both modes and compares each flag to values it computes arithmetically, with directed passes over the most negative and all-ones operands.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic s;
    } cmp_flags_t;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/cmp_sub_core.sv
module cmp_sub_core #(
    parameter int WIDTH      = 16,
    parameter bit USE_RIPPLE = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] diff,
    output logic             carry_out
);

    localparam int CHAIN = WIDTH + 1;

    generate
        if (USE_RIPPLE) begin : g_ripple
            logic [CHAIN-1:0] cy;
            assign cy[0] = 1'b1;
            for (genvar i = 0; i < WIDTH; i++) begin : g_cell
                logic x_bit;
                logic y_bit;
                assign x_bit     = b[i];
                assign y_bit     = ~a[i];
                assign diff[i]   = x_bit ^ y_bit ^ cy[i];
                assign cy[i+1]   = (x_bit & y_bit) | (cy[i] & (x_bit ^ y_bit));
            end
            assign carry_out = cy[CHAIN-1];
        end else begin : g_behav
            logic [WIDTH:0] sum_ext;
            assign sum_ext   = {1'b0, b} + {1'b0, ~a} + {{WIDTH{1'b0}}, 1'b1};
            assign diff      = sum_ext[WIDTH-1:0];
            assign carry_out = sum_ext[WIDTH];
        end
    endgenerate

endmodule

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen
    import cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] diff,
    input  logic             carry_out,
    input  logic             a_msb,
    input  logic             b_msb,
    output cmp_flags_t       flags
);

    localparam int MSB = WIDTH - 1;

    logic signs_differ;
    logic result_flipped;

    always_comb begin
        signs_differ   = a_msb ^ b_msb;
        result_flipped = diff[MSB] ^ b_msb;
        flags.c        = carry_out;
        flags.z        = ~(|diff);
        flags.n        = diff[MSB];
        flags.v        = signs_differ & result_flipped;
        flags.s        = flags.n ^ flags.v;
    end

endmodule

// File: rtl/cmp_eq_detect.sv
module cmp_eq_detect #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             eq
);

    logic [WIDTH-1:0] bit_same;

    assign bit_same = a ~^ b;
    assign eq       = &bit_same;

endmodule

// File: rtl/sub_cmp_top.sv
module sub_cmp_top
    import cmp_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter bit USE_RIPPLE = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             signed_mode,
    output logic             flag_c,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_s,
    output logic             a_lt_b,
    output logic             a_eq_b
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] diff;
    logic             carry_out;
    cmp_flags_t       flags;
    logic             eq_xnor;
    logic             lt_unsigned;
    logic             lt_signed;
    cmp_mode_e        mode;

    cmp_sub_core #(
        .WIDTH     (WIDTH),
        .USE_RIPPLE(USE_RIPPLE)
    ) u_core (
        .a        (a),
        .b        (b),
        .diff     (diff),
        .carry_out(carry_out)
    );

    cmp_flag_gen #(
        .WIDTH(WIDTH)
    ) u_flags (
        .diff     (diff),
        .carry_out(carry_out),
        .a_msb    (a[MSB]),
        .b_msb    (b[MSB]),
        .flags    (flags)
    );

    cmp_eq_detect #(
        .WIDTH(WIDTH)
    ) u_eq (
        .a (a),
        .b (b),
        .eq(eq_xnor)
    );

    always_comb begin
        mode        = cmp_mode_e'(signed_mode);
        lt_unsigned = flags.c & ~flags.z;
        lt_signed   = ~flags.s & ~flags.z;
        unique case (mode)
            CMP_UNSIGNED: a_lt_b = lt_unsigned;
            CMP_SIGNED:   a_lt_b = lt_signed;
            default:      a_lt_b = 1'b0;
        endcase
    end

    assign flag_c = flags.c;
    assign flag_z = flags.z;
    assign flag_n = flags.n;
    assign flag_v = flags.v;
    assign flag_s = flags.s;
    assign a_eq_b = eq_xnor;

    // Checks relating separately built pieces of logic.
    always_comb begin
        p_eq_agrees_zero_r6: assert (eq_xnor == flags.z)
            else $error("R6: XNOR equality disagrees with zero flag");
        p_zero_carries_r2: assert (!flags.z || flags.c)
            else $error("R2: zero difference without carry-out");
        p_no_overflow_r4: assert (!flags.v || (a[MSB] != b[MSB]))
            else $error("R4: overflow with operands of equal sign");
        p_unsigned_lt_r7: assert (mode != CMP_UNSIGNED || a_lt_b == (a < b))
            else $error("R7: unsigned less-than mismatch");
        p_signed_lt_r8: assert (mode != CMP_SIGNED || a_lt_b == ($signed(a) < $signed(b)))
            else $error("R8: signed less-than mismatch");
        p_carry_is_ge_r1: assert (flags.c == (b >= a))
            else $error("R1: carry does not match unsigned b >= a");
    end

endmodule

// File: tb/sim_sub_cmp_top.sv
module sim_sub_cmp_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 6;
    localparam int SPAN       = 1 << W;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         signed_mode = 1'b0;
    logic         flag_c, flag_z, flag_n, flag_v, flag_s, a_lt_b, a_eq_b;

    int n_tests = 0;
    int n_fail  = 0;

    sub_cmp_top #(.WIDTH(W), .USE_RIPPLE(1'b1)) u0 (
        .a          (a),
        .b          (b),
        .signed_mode(signed_mode),
        .flag_c     (flag_c),
        .flag_z     (flag_z),
        .flag_n     (flag_n),
        .flag_v     (flag_v),
        .flag_s     (flag_s),
        .a_lt_b     (a_lt_b),
        .a_eq_b     (a_eq_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s a=%0d b=%0d mode=%0d actual=%0b expected=%0b",
                     req, what, a, b, signed_mode, act, exp);
        end
    endtask

    function automatic int to_signed(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - SPAN : int'(v);
    endfunction

    task automatic apply_and_check(input int av, input int bv, input logic md, input bit tag_r9);
        int           sa, sb;
        logic [W-1:0] d;
        logic         e_c, e_z, e_n, e_v, e_s, e_lt;
        @(posedge clk);
        a           = W'(av);
        b           = W'(bv);
        signed_mode = md;
        @(negedge clk);
        sa  = to_signed(W'(av));
        sb  = to_signed(W'(bv));
        d   = W'((bv - av + SPAN) % SPAN);
        e_c = (bv >= av);
        e_z = (av == bv);
        e_n = d[W-1];
        e_v = (a[W-1] != b[W-1]) && (d[W-1] != b[W-1]);
        e_s = (sb < sa);
        e_lt = md ? (sa < sb) : (av < bv);
        chk("R1", "flag_c", flag_c, e_c);
        chk("R2", "flag_z", flag_z, e_z);
        chk("R3", "flag_n", flag_n, e_n);
        chk("R4", "flag_v", flag_v, e_v);
        chk("R5", "flag_s", flag_s, e_s);
        chk("R5", "flag_s_xor", flag_s, flag_n ^ flag_v);
        chk("R6", "a_eq_b", a_eq_b, e_z);
        if (tag_r9)
            chk("R9", "a_lt_b", a_lt_b, e_lt);
        else if (md)
            chk("R8", "a_lt_b", a_lt_b, e_lt);
        else
            chk("R7", "a_lt_b", a_lt_b, e_lt);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiescent state: both operands zero, unsigned mode.
        @(negedge clk);
        chk("R2", "idle flag_z", flag_z, 1'b1);
        chk("R6", "idle a_eq_b", a_eq_b, 1'b1);
        chk("R7", "idle a_lt_b", a_lt_b, 1'b0);
        chk("R1", "idle flag_c", flag_c, 1'b1);
        // Directed extremes: most negative value and all ones, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < SPAN; k++) begin
                apply_and_check(SPAN/2, k, logic'(m), 1'b1);
                apply_and_check(k, SPAN/2, logic'(m), 1'b1);
                apply_and_check(SPAN-1, k, logic'(m), 1'b1);
                apply_and_check(k, SPAN-1, logic'(m), 1'b1);
            end
        end
        // Exhaustive sweep of every operand pair in both modes.
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < SPAN; x++)
                for (int y = 0; y < SPAN; y++)
                    apply_and_check(x, y, logic'(m), 1'b0);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule